// File: doc/BRIEF.md
# Indexed stream register bank

This block is one lane's slice of stream register storage. It is built from four independent sub-arrays, each with its own row decoder and a one-of-eight word selector on its 256-bit row. It answers two kinds of traffic. A sequential request moves a 128-bit block of four contiguous words into or out of a single sub-array. An indexed read is a word address that the compute cluster pushes into an address queue. The bank later resolves it to one 32-bit word, which waits in a return queue until the cluster collects it. Issuing an address and collecting the data are separate operations, so the cluster can do other work between them.

Each cycle the scheduler puts the cycle into one of four slots. `SLOT_SEQ` applies whenever a sequential request is present, and it takes the whole cycle. `SLOT_INDEX` applies when at least one queued address is granted. `SLOT_WAIT` applies when addresses are queued but none can be granted. `SLOT_IDLE` applies when there is nothing to do. The slot is decided afresh every cycle, so any slot can follow any other. A `SLOT_SEQ` cycle leaves the queued addresses in place for the next non-sequential cycle. `SLOT_WAIT` turns into `SLOT_INDEX` as soon as the return queue has room. A registered copy of the slot marks the cycle in which sequential read data is valid.

In an indexed cycle, addresses are taken from the head of the queue in order. The group ends at the first address whose sub-array has already been claimed in that cycle, or when the return queue has no space left. A single cycle can therefore complete up to four reads.

Top module: `isrb_bank`

## Requirements
- R1: A 10-bit word address is decoded as bits [2:0] = word within row, bits [4:3] = sub-array, bits [9:5] = row. An indexed read returns the word last written at that address.
- R2: A sequential write to block address `b` (8 bits) stores 32-bit lane `i` of `seq_wdata` (bits [32i+31:32i]) at word address 4·b+i, for i = 0..3.
- R3: A sequential read of block `b` sets `seq_rvalid` on the cycle after the request and presents words 4·b..4·b+3 on `seq_rdata`, with the same lane layout as R2.
- R4: Indexed read data leaves the return queue in the order the addresses were pushed.
- R5: In one cycle the bank grants queued addresses from the head in order. It stops at the first address whose sub-array is already taken in that cycle. Four addresses in four distinct sub-arrays all complete in one cycle. Four addresses in one sub-array complete one per cycle. The pattern sub-arrays 0,1,0,2 completes two in the first cycle.
- R6: While `seq_req` is high no indexed read is granted. Addresses waiting in the queue are kept and served later.
- R7: The address queue holds 8 entries. `idx_full` is high while it holds 8. A push while `idx_full` is high is discarded.
- R8: `dat_stall` is high in a cycle where `dat_pop` is high and `dat_valid` is low. Such a pop changes nothing.
- R9: After reset, `idx_full`, `dat_valid`, `seq_rvalid` and `dat_stall` are low.
- R10: A grant is made only when the 8-entry return queue has space for it. When the cluster does not pop, no read result is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_req | input | 1 | Sequential block access in this cycle |
| seq_we | input | 1 | 1 = block write, 0 = block read |
| seq_blk | input | 8 | Block address (word address / 4) |
| seq_wdata | input | 128 | Block write data, word i in bits [32i+31:32i] |
| seq_rdata | output | 128 | Block read data, valid with `seq_rvalid` |
| seq_rvalid | output | 1 | Block read data valid (one cycle after request) |
| idx_push | input | 1 | Push an indexed read address |
| idx_addr | input | 10 | Word address to read |
| idx_full | output | 1 | Address queue full; push is discarded |
| dat_pop | input | 1 | Collect one indexed read word |
| dat_word | output | 32 | Oldest returned word |
| dat_valid | output | 1 | Return queue holds a word |
| dat_stall | output | 1 | Pop requested while no word is ready |

## Verification
Every word is first written through sequential blocks. Indexed reads are then swept in three orders: plain ascending, a rotation that places consecutive addresses in different sub-arrays, and an odd-stride permutation. The ascending sweep piles eight reads onto one sub-array in turn, while the rotation allows four grants per cycle, so together they test ordering and data under both the worst and the best grouping. Grants are counted through a single indexed cycle enclosed between sequential requests. Three address patterns are used: all distinct, all in one sub-array, and a conflict in the middle. These show whether the scheduler stops at the first clash or skips past it. Filling the address queue without pops, and reading more than the return queue holds, exercise the back-pressure paths.

// File: rtl/isrb_pkg.sv
package isrb_pkg;
    localparam int WORD_W    = 32;
    localparam int NSUB      = 4;
    localparam int WPR       = 8;
    localparam int ROWS      = 32;
    localparam int BLK_WORDS = 4;

    localparam int WSEL_W   = $clog2(WPR);
    localparam int SUB_W    = $clog2(NSUB);
    localparam int ROW_W    = $clog2(ROWS);
    localparam int HALF_W   = $clog2(WPR / BLK_WORDS);
    localparam int ADDR_W   = WSEL_W + SUB_W + ROW_W;
    localparam int BLK_A_W  = ADDR_W - $clog2(BLK_WORDS);
    localparam int BLK_W    = WORD_W * BLK_WORDS;
    localparam int ROW_BITS = WORD_W * WPR;

    typedef logic [ADDR_W-1:0] waddr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SUB_W-1:0]  sub_t;

    typedef enum logic [1:0] {
        SLOT_IDLE,
        SLOT_SEQ,
        SLOT_INDEX,
        SLOT_WAIT
    } slot_t;

    function automatic sub_t sub_of(waddr_t a);
        return a[WSEL_W +: SUB_W];
    endfunction

    function automatic logic [ROW_W-1:0] row_of(waddr_t a);
        return a[WSEL_W + SUB_W +: ROW_W];
    endfunction

    function automatic logic [WSEL_W-1:0] wsel_of(waddr_t a);
        return a[WSEL_W-1:0];
    endfunction
endpackage

// File: rtl/isrb_fifo.sv
module isrb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int NIN   = 1,
    parameter int NOUT  = 1,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CW-1:0]            push_n,
    input  logic [NIN-1:0][W-1:0]    push_data,
    input  logic [CW-1:0]            pop_n,
    output logic [NOUT-1:0][W-1:0]   peek,
    output logic [CW-1:0]            count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + push_n[PW-1:0];
            rd_ptr <= rd_ptr + pop_n[PW-1:0];
            count  <= count + push_n - pop_n;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NIN; i++) begin
            if (CW'(i) < push_n) mem[wr_ptr + PW'(i)] <= push_data[i];
        end
    end

    always_comb begin
        for (int j = 0; j < NOUT; j++) peek[j] = mem[rd_ptr + PW'(j)];
    end

    // R7 R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_n <= (CW'(DEPTH) - count));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_n <= count);
endmodule

// File: rtl/isrb_arb.sv
module isrb_arb
    import isrb_pkg::*;
#(
    parameter int CW_A = 4,
    parameter int CW_R = 4,
    localparam int GW  = $clog2(NSUB + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          seq_req,
    input  logic [NSUB-1:0][ADDR_W-1:0]   head,
    input  logic [CW_A-1:0]               avail,
    input  logic [CW_R-1:0]               room,
    output slot_t                         slot,
    output logic [GW-1:0]                 n_grant,
    output logic [NSUB-1:0]               used,
    output logic [NSUB-1:0][ROW_W-1:0]    sub_row,
    output logic [NSUB-1:0][WSEL_W-1:0]   sub_wsel,
    output logic [NSUB-1:0][SUB_W-1:0]    grant_sub
);
    always_comb begin
        logic stop;
        sub_t s;
        stop      = 1'b0;
        s         = '0;
        n_grant   = '0;
        used      = '0;
        sub_row   = '0;
        sub_wsel  = '0;
        grant_sub = '0;
        if (!seq_req) begin
            for (int k = 0; k < NSUB; k++) begin
                s = sub_of(head[k]);
                if (!stop && (CW_A'(k) < avail) && (CW_R'(k) < room) && !used[s]) begin
                    used[s]      = 1'b1;
                    sub_row[s]   = row_of(head[k]);
                    sub_wsel[s]  = wsel_of(head[k]);
                    grant_sub[k] = s;
                    n_grant      = GW'(k + 1);
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (seq_req)               slot = SLOT_SEQ;
        else if (n_grant != '0)    slot = SLOT_INDEX;
        else if (avail != '0)      slot = SLOT_WAIT;
        else                       slot = SLOT_IDLE;
    end

    // R5
    one_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(used) == int'(n_grant));
endmodule

// File: rtl/isrb_subarray.sv
module isrb_subarray
    import isrb_pkg::*;
(
    input  logic               clk,
    input  logic [ROW_W-1:0]   row,
    input  logic [WSEL_W-1:0]  wsel,
    input  logic [HALF_W-1:0]  half,
    input  logic               blk_we,
    input  logic [BLK_W-1:0]   blk_wdata,
    output word_t              word_o,
    output logic [BLK_W-1:0]   blk_o
);
    logic [ROW_BITS-1:0] mem [ROWS];
    logic [ROW_BITS-1:0] row_q;

    always_ff @(posedge clk) begin
        if (blk_we) mem[row][BLK_W*int'(half) +: BLK_W] <= blk_wdata;
    end

    assign row_q  = mem[row];
    assign word_o = row_q[WORD_W*int'(wsel) +: WORD_W];
    assign blk_o  = row_q[BLK_W*int'(half) +: BLK_W];
endmodule

// File: rtl/isrb_bank.sv
module isrb_bank
    import isrb_pkg::*;
#(
    parameter int AF_DEPTH = 8,
    parameter int RF_DEPTH = 8,
    localparam int CW_A    = $clog2(AF_DEPTH + 1),
    localparam int CW_R    = $clog2(RF_DEPTH + 1),
    localparam int GW      = $clog2(NSUB + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seq_req,
    input  logic                seq_we,
    input  logic [BLK_A_W-1:0]  seq_blk,
    input  logic [BLK_W-1:0]    seq_wdata,
    output logic [BLK_W-1:0]    seq_rdata,
    output logic                seq_rvalid,
    input  logic                idx_push,
    input  logic [ADDR_W-1:0]   idx_addr,
    output logic                idx_full,
    input  logic                dat_pop,
    output logic [WORD_W-1:0]   dat_word,
    output logic                dat_valid,
    output logic                dat_stall
);
    logic [CW_A-1:0]                  af_cnt, af_push_n, af_pop_n;
    logic [NSUB-1:0][ADDR_W-1:0]      af_head;
    logic [CW_R-1:0]                  rf_cnt, rf_push_n, rf_pop_n, rf_room;
    logic [NSUB-1:0][WORD_W-1:0]      rf_push_data;
    logic [0:0][WORD_W-1:0]           rf_peek;

    slot_t                            slot, slot_q;
    logic                             wr_q;
    logic [GW-1:0]                    n_grant;
    logic [NSUB-1:0]                  arb_used;
    logic [NSUB-1:0][ROW_W-1:0]       arb_row;
    logic [NSUB-1:0][WSEL_W-1:0]      arb_wsel;
    logic [NSUB-1:0][SUB_W-1:0]       grant_sub;

    logic [HALF_W-1:0]                seq_half;
    sub_t                             seq_sub;
    logic [ROW_W-1:0]                 seq_row;
    logic [NSUB-1:0][ROW_W-1:0]       s_row;
    logic [NSUB-1:0][WSEL_W-1:0]      s_wsel;
    logic [NSUB-1:0]                  s_we;
    logic [NSUB-1:0][WORD_W-1:0]      sub_word;
    logic [NSUB-1:0][BLK_W-1:0]       sub_blk;

    assign seq_half = seq_blk[HALF_W-1:0];
    assign seq_sub  = seq_blk[HALF_W +: SUB_W];
    assign seq_row  = seq_blk[HALF_W + SUB_W +: ROW_W];

    assign idx_full  = (af_cnt == CW_A'(AF_DEPTH));
    assign af_push_n = CW_A'(idx_push && !idx_full);
    assign af_pop_n  = CW_A'(n_grant);
    assign rf_room   = CW_R'(RF_DEPTH) - rf_cnt;
    assign rf_push_n = CW_R'(n_grant);

    isrb_fifo #(.W(ADDR_W), .DEPTH(AF_DEPTH), .NIN(1), .NOUT(NSUB)) u_addr_q (
        .clk(clk), .rst_n(rst_n), .push_n(af_push_n), .push_data(idx_addr),
        .pop_n(af_pop_n), .peek(af_head), .count(af_cnt));

    isrb_arb #(.CW_A(CW_A), .CW_R(CW_R)) u_arb (
        .clk(clk), .rst_n(rst_n), .seq_req(seq_req), .head(af_head),
        .avail(af_cnt), .room(rf_room), .slot(slot), .n_grant(n_grant),
        .used(arb_used), .sub_row(arb_row), .sub_wsel(arb_wsel),
        .grant_sub(grant_sub));

    // Output process: sub-array controls per slot
    always_comb begin
        s_row  = '0;
        s_wsel = '0;
        s_we   = '0;
        unique case (slot)
            SLOT_SEQ: begin
                for (int s = 0; s < NSUB; s++) begin
                    s_row[s] = seq_row;
                    s_we[s]  = seq_we && (SUB_W'(s) == seq_sub);
                end
            end
            SLOT_INDEX: begin
                s_row  = arb_row;
                s_wsel = arb_wsel;
            end
            SLOT_WAIT, SLOT_IDLE: ;
        endcase
    end

    for (genvar g = 0; g < NSUB; g++) begin : g_sub
        isrb_subarray u_sub (
            .clk(clk), .row(s_row[g]), .wsel(s_wsel[g]), .half(seq_half),
            .blk_we(s_we[g]), .blk_wdata(seq_wdata),
            .word_o(sub_word[g]), .blk_o(sub_blk[g]));
    end

    always_comb begin
        for (int k = 0; k < NSUB; k++) rf_push_data[k] = sub_word[grant_sub[k]];
    end

    isrb_fifo #(.W(WORD_W), .DEPTH(RF_DEPTH), .NIN(NSUB), .NOUT(1)) u_ret_q (
        .clk(clk), .rst_n(rst_n), .push_n(rf_push_n), .push_data(rf_push_data),
        .pop_n(rf_pop_n), .peek(rf_peek), .count(rf_cnt));

    assign dat_valid = (rf_cnt != '0);
    assign dat_word  = rf_peek[0];
    assign rf_pop_n  = CW_R'(dat_pop && dat_valid);
    assign dat_stall = dat_pop && !dat_valid;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q    <= SLOT_IDLE;
            wr_q      <= 1'b0;
            seq_rdata <= '0;
        end else begin
            slot_q <= slot;
            wr_q   <= seq_we;
            if (slot == SLOT_SEQ && !seq_we) seq_rdata <= sub_blk[seq_sub];
        end
    end

    assign seq_rvalid = (slot_q == SLOT_SEQ) && !wr_q;

    // R3
    seq_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req && !seq_we) |=> seq_rvalid);

    // R6
    seq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req |-> (arb_used == '0 && rf_push_n == '0 && af_pop_n == '0));
endmodule

// File: tb/isrb_bank_bench.sv
`timescale 1ns/1ps
module isrb_bank_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         seq_req = 1'b0, seq_we = 1'b0;
    logic [7:0]   seq_blk = '0;
    logic [127:0] seq_wdata = '0;
    logic [127:0] seq_rdata;
    logic         seq_rvalid;
    logic         idx_push = 1'b0;
    logic [9:0]   idx_addr = '0;
    logic         idx_full;
    logic         dat_pop = 1'b0;
    logic [31:0]  dat_word;
    logic         dat_valid, dat_stall;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] model [1024];
    logic [9:0]  rd_addr [1024];

    always #2 clk = ~clk;

    isrb_bank u_isrb_bank (
        .clk(clk), .rst_n(rst_n), .seq_req(seq_req), .seq_we(seq_we),
        .seq_blk(seq_blk), .seq_wdata(seq_wdata), .seq_rdata(seq_rdata),
        .seq_rvalid(seq_rvalid), .idx_push(idx_push), .idx_addr(idx_addr),
        .idx_full(idx_full), .dat_pop(dat_pop), .dat_word(dat_word),
        .dat_valid(dat_valid), .dat_stall(dat_stall));

    function automatic logic [31:0] pat(int a, int gen);
        return (32'(a) * 32'h9E3779B1) ^ 32'hC3A50000 ^ (32'(gen) << 28);
    endfunction

    function automatic logic [9:0] mk(int row, int sub, int w);
        return 10'((row << 5) | (sub << 3) | w);
    endfunction

    task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic seq_write(int b, int gen);
        logic [127:0] d;
        for (int i = 0; i < 4; i++) begin
            d[32*i +: 32] = pat(4*b + i, gen);
            model[4*b + i] = pat(4*b + i, gen);
        end
        @(negedge clk);
        seq_req = 1'b1; seq_we = 1'b1; seq_blk = 8'(b); seq_wdata = d;
        @(negedge clk);
        seq_req = 1'b0; seq_we = 1'b0;
    endtask

    task automatic seq_read(int b);
        logic [127:0] e;
        for (int i = 0; i < 4; i++) e[32*i +: 32] = model[4*b + i];
        @(negedge clk);
        seq_req = 1'b1; seq_we = 1'b0; seq_blk = 8'(b);
        @(negedge clk);
        check(seq_rvalid == 1'b1, "R3 seq_rvalid", 128'(seq_rvalid), 128'd1);
        check(seq_rdata == e, "R2 R3 block data", seq_rdata, e);
        seq_req = 1'b0;
    endtask

    // Stream n indexed reads from rd_addr[], pushing and popping together.
    task automatic run_reads(int n, string tag);
        fork
            begin
                int pushed = 0;
                while (pushed < n) begin
                    @(negedge clk);
                    if (!idx_full) begin
                        idx_push = 1'b1; idx_addr = rd_addr[pushed]; pushed++;
                    end else idx_push = 1'b0;
                end
                @(negedge clk);
                idx_push = 1'b0;
            end
            begin
                int got = 0;
                int guard = 0;
                while (got < n && guard < 20000) begin
                    @(negedge clk);
                    guard++;
                    if (dat_valid) begin
                        check(dat_word == model[rd_addr[got]], tag, 128'(dat_word),
                              128'(model[rd_addr[got]]));
                        dat_pop = 1'b1; got++;
                    end else dat_pop = 1'b0;
                end
                check(got == n, {tag, " count"}, 128'(got), 128'(n));
                @(negedge clk);
                dat_pop = 1'b0;
            end
        join
    endtask

    // Collect words while available, comparing with rd_addr[first..]
    task automatic collect(int first, int limit, string tag, output int cnt);
        cnt = 0;
        while (dat_valid && cnt < limit) begin
            check(dat_word == model[rd_addr[first + cnt]], tag, 128'(dat_word),
                  128'(model[rd_addr[first + cnt]]));
            dat_pop = 1'b1; cnt++;
            @(negedge clk);
        end
        dat_pop = 1'b0;
    endtask

    task automatic drain(int first, int n, string tag);
        int got = 0;
        int guard = 0;
        while (got < n && guard < 200) begin
            @(negedge clk);
            guard++;
            if (dat_valid) begin
                check(dat_word == model[rd_addr[first + got]], tag, 128'(dat_word),
                      128'(model[rd_addr[first + got]]));
                dat_pop = 1'b1; got++;
            end else dat_pop = 1'b0;
        end
        check(got == n, {tag, " drained"}, 128'(got), 128'(n));
        @(negedge clk);
        dat_pop = 1'b0;
    endtask

    // One indexed cycle enclosed by sequential requests; count words granted
    task automatic group_test(logic [9:0] a0, a1, a2, a3, int exp_n, string tag);
        int cnt;
        rd_addr[0] = a0; rd_addr[1] = a1; rd_addr[2] = a2; rd_addr[3] = a3;
        @(negedge clk);
        seq_req = 1'b1; seq_we = 1'b0; seq_blk = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            idx_push = 1'b1; idx_addr = rd_addr[i];
        end
        @(negedge clk);
        idx_push = 1'b0; seq_req = 1'b0;
        @(negedge clk);
        seq_req = 1'b1;
        @(negedge clk);
        collect(0, 8, {tag, " data"}, cnt);
        check(cnt == exp_n, {tag, " words per cycle"}, 128'(cnt), 128'(exp_n));
        seq_req = 1'b0;
        // R6: remaining addresses were held, not dropped
        drain(cnt, 4 - cnt, "R6 held reads");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(idx_full == 1'b0, "R9 idx_full", 128'(idx_full), 128'd0);
        check(dat_valid == 1'b0, "R9 dat_valid", 128'(dat_valid), 128'd0);
        check(seq_rvalid == 1'b0, "R9 seq_rvalid", 128'(seq_rvalid), 128'd0);
        check(dat_stall == 1'b0, "R9 dat_stall", 128'(dat_stall), 128'd0);
        rst_n = 1'b1;

        // R2: fill the whole bank through block writes
        for (int b = 0; b < 256; b++) seq_write(b, 0);
        for (int b = 0; b < 256; b += 17) seq_read(b);

        // R1 R4: ascending sweep (eight same-sub-array reads in a row)
        for (int k = 0; k < 1024; k++) rd_addr[k] = 10'(k);
        run_reads(1024, "R1 R4 ascending");
        // R1 R4: rotating sub-arrays, four grants per cycle
        for (int k = 0; k < 1024; k++)
            rd_addr[k] = mk(k / 32, k % 4, (k / 4) % 8);
        run_reads(1024, "R1 R4 rotating");
        // R1 R4: odd-stride permutation
        for (int k = 0; k < 1024; k++) rd_addr[k] = 10'((k * 389 + 17) % 1024);
        run_reads(1024, "R1 R4 stride");

        // R2: overwrite blocks, then read back both ways
        seq_write(5, 1); seq_write(100, 1); seq_write(255, 1);
        seq_read(5); seq_read(100); seq_read(255);
        for (int i = 0; i < 4; i++) begin
            rd_addr[i] = 10'(20 + i); rd_addr[4 + i] = 10'(400 + i);
            rd_addr[8 + i] = 10'(1020 + i);
        end
        run_reads(12, "R2 overwritten words");

        // R5 grouping
        group_test(mk(3,0,1), mk(7,1,2), mk(9,2,3), mk(30,3,7), 4, "R5 distinct");
        group_test(mk(1,2,0), mk(4,2,5), mk(8,2,6), mk(2,2,1), 1, "R5 same sub");
        group_test(mk(6,0,0), mk(6,1,1), mk(11,0,2), mk(12,2,3), 2, "R5 mid conflict");

        // R7: fill the address queue while sequential traffic blocks grants
        for (int i = 0; i < 10; i++) rd_addr[i] = 10'(i * 97 + 3);
        @(negedge clk);
        seq_req = 1'b1; seq_we = 1'b0; seq_blk = '0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i == 7) check(idx_full == 1'b0, "R7 not full at 7", 128'(idx_full), 128'd0);
            idx_push = 1'b1; idx_addr = rd_addr[i];
        end
        @(negedge clk);
        idx_push = 1'b0;
        check(idx_full == 1'b1, "R7 full at 8", 128'(idx_full), 128'd1);
        seq_req = 1'b0;
        drain(0, 8, "R7 kept entries");
        repeat (3) @(negedge clk);
        check(dat_valid == 1'b0, "R7 extra pushes discarded", 128'(dat_valid), 128'd0);

        // R8: pop on empty
        dat_pop = 1'b1;
        #1;
        check(dat_stall == 1'b1, "R8 stall on empty pop", 128'(dat_stall), 128'd1);
        @(negedge clk);
        dat_pop = 1'b0;
        #1;
        check(dat_stall == 1'b0, "R8 stall clears", 128'(dat_stall), 128'd0);
        check(dat_valid == 1'b0, "R8 empty pop no effect", 128'(dat_valid), 128'd0);
        rd_addr[0] = 10'd777;
        @(negedge clk);
        idx_push = 1'b1; idx_addr = rd_addr[0];
        @(negedge clk);
        idx_push = 1'b0;
        drain(0, 1, "R8 after stall");

        // R10: 16 reads with no pops, then collect all in order
        for (int i = 0; i < 16; i++) rd_addr[i] = mk(i, i % 4, 7 - (i % 8));
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            check(idx_full == 1'b0, "R10 room while filling", 128'(idx_full), 128'd0);
            idx_push = 1'b1; idx_addr = rd_addr[i];
        end
        @(negedge clk);
        idx_push = 1'b0;
        repeat (6) @(negedge clk);
        check(idx_full == 1'b1, "R10 backlog held", 128'(idx_full), 128'd1);
        collect(0, 16, "R10 backlog data", cnt);
        check(cnt == 16, "R10 none lost", 128'(cnt), 128'd16);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule